// File: doc/BRIEF.md
# Serial Management Interface Target (PHY side)

This block is the PHY-side target of a two-wire serial management interface. A station toggles a management clock and drives a data line (with an output enable); the target samples that line on each rising clock edge and shifts the bits into a 32-bit history register. The history register lets the target find a run of 32 ones, which restarts frame alignment. It then decodes a 16-bit command header made of start code, opcode, PHY address, register address and turnaround.

A valid read fetches one entry of a 32 x 16 register file and returns it on the target's data output, most significant bit first, one bit per management clock edge. A valid write collects 16 data bits and stores them in the addressed entry. After reset every entry is zero except two identifier entries, which hold fixed values. The PHY address field is not decoded, so every address selects the same register file. The management clock and data inputs are expected to be already synchronous to `clk`.

Top module: `mdio_mgmt_target`

## Requirements
- R1: After reset, entry 2 reads 0x0022, entry 3 reads 0x161A, every other entry reads 0x0000, and `mdi` is 0.
- R2: A bit is taken only on a rising edge of `mdc`, seen as `mdc` high in a `clk` cycle after a cycle with `mdc` low. The bit is 1 only when both `mdo` and `mdo_oe` are 1. While `mdc` does not rise, changes on `mdo` have no effect.
- R3: When the last 32 bits taken are all ones, the target returns to idle with its bit count cleared, so the next 16 bits are decoded as a header. In idle, a header is decoded only on the 16th bit counted since reset, since the last run of ones, or since the last completed frame. After a rejected header, later bits are not decoded until a run of 32 ones is received.
- R4: The 16-bit header is laid out from first bit to last as follows: start in bits 15:14, opcode in 13:12, PHY address in 11:7, register address in 6:2, and turnaround in 1:0. Bit 0 is the last bit received.
- R5: A write is accepted only when start = 01, opcode = 01 and turnaround = 10. Any other header starts no write and leaves the register file unchanged.
- R6: A read is accepted when start = 01, opcode = 10 and turnaround bit 0 = 0. A turnaround of 00 (station not driving) or 10 both qualify. Any other header leaves `mdi` at 0.
- R7: For an accepted read, `mdi` shows data bit 15 after the `clk` edge that takes the last turnaround bit. After the k-th following `mdc` rising edge it shows bit 15-k, for k = 1..15. On the 16th rising edge the read ends and `mdi` returns to 0.
- R8: For an accepted write, the 16 data bits that follow the header are stored, first bit as bit 15, on the 16th data edge. The target then goes to idle with its count cleared, so a following frame needs no run of ones.
- R9: The PHY address field is ignored: any PHY address reaches the same register file.
- R10: `mdi` is 0 whenever the target is not in the data phase of an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the management inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock from the station, synchronous to `clk` |
| mdo | input | 1 | Data driven by the station |
| mdo_oe | input | 1 | Station output enable; when low, the sampled bit is 0 |
| mdi | output | 1 | Data returned to the station during a read |

## Verification
The hardest state to reach from the ports is the header counter after a rejected header. In that state the target must stay silent through valid-looking headers until a run of 32 ones realigns it. The bench first sends a frame with a bad start code and then, without a run of ones, a valid write. It confirms by reading back that the write was lost. Then, after a run of ones, it confirms the same write is taken. A second hard case is the two turnaround rules: the bench drives the turnaround itself so that reads with 10 and 01 and writes with 11 can be compared against the register contents.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } frm_state_e;

  localparam logic [1:0] HDR_START = 2'b01;
  localparam logic [1:0] HDR_OP_WR = 2'b01;
  localparam logic [1:0] HDR_OP_RD = 2'b10;
  localparam logic [1:0] HDR_TA_WR = 2'b10;

endpackage

// File: rtl/mdio_edge.sv
module mdio_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdo,
  input  logic mdo_oe,
  output logic rise,
  output logic bit_in
);

  logic mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_q <= 1'b0;
    else        mdc_q <= mdc;
  end

  assign rise   = mdc & ~mdc_q;
  assign bit_in = mdo & mdo_oe;

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned ID_A_IDX = 2,
  parameter logic [DATA_W-1:0] ID_A_VAL = 16'h0022,
  parameter int unsigned ID_B_IDX = 3,
  parameter logic [DATA_W-1:0] ID_B_VAL = 16'h161A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_ent
    localparam logic [DATA_W-1:0] RST_VAL =
      (gi == ID_A_IDX) ? ID_A_VAL :
      (gi == ID_B_IDX) ? ID_B_VAL : '0;
    logic ent_en;
    assign ent_en = we && (waddr == ADDR_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[gi] <= RST_VAL;
      else if (ent_en) mem_q[gi] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_tgt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              bit_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              mdi,
  output frm_state_e        state,
  output logic [$clog2(DATA_W+2)-1:0] cnt,
  output logic [2*DATA_W-1:0] hist
);

  localparam int unsigned SH_W  = 2 * DATA_W;
  localparam int unsigned CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DATA_W);
  localparam int unsigned REG_LO = 2;

  frm_state_e        st_q, st_n;
  logic [SH_W-1:0]   sh_q, sh_n, shift_w;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] dout_q, dout_n;
  logic              mdi_q, mdi_n;
  logic              hdr_wr, hdr_rd;
  logic [1:0]        f_start, f_op, f_ta;

  assign shift_w = {sh_q[SH_W-2:0], bit_in};
  assign f_start = shift_w[DATA_W-1 -: 2];
  assign f_op    = shift_w[DATA_W-3 -: 2];
  assign f_ta    = shift_w[1:0];
  assign hdr_wr  = (f_start == HDR_START) && (f_op == HDR_OP_WR) && (f_ta == HDR_TA_WR);
  assign hdr_rd  = (f_start == HDR_START) && (f_op == HDR_OP_RD) && !f_ta[0];
  assign rd_addr = shift_w[REG_LO +: ADDR_W];
  assign waddr   = addr_q;
  assign wdata   = shift_w[DATA_W-1:0];

  always_comb begin
    st_n   = st_q;
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    dout_n = dout_q;
    mdi_n  = mdi_q;
    we     = 1'b0;
    if (rise) begin
      sh_n = shift_w;
      if (&shift_w) begin
        st_n  = ST_IDLE;
        cnt_n = '0;
        mdi_n = 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (cnt_q != CNT_SAT) cnt_n = cnt_q + 1'b1;
            if (cnt_q == HDR_LAST) begin
              if (hdr_wr) begin
                st_n   = ST_WR;
                cnt_n  = CNT_LOAD;
                addr_n = rd_addr;
              end else if (hdr_rd) begin
                st_n   = ST_RD;
                cnt_n  = CNT_LOAD;
                addr_n = rd_addr;
                mdi_n  = rd_data[DATA_W-1];
                dout_n = {rd_data[DATA_W-2:0], 1'b0};
              end
            end
          end
          ST_WR: begin
            cnt_n = cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
              we    = 1'b1;
              st_n  = ST_IDLE;
              cnt_n = '0;
            end
          end
          ST_RD: begin
            cnt_n = cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
              mdi_n = 1'b0;
              st_n  = ST_IDLE;
              cnt_n = '0;
            end else begin
              mdi_n  = dout_q[DATA_W-1];
              dout_n = {dout_q[DATA_W-2:0], 1'b0};
            end
          end
          default: begin
            st_n  = ST_IDLE;
            cnt_n = '0;
            mdi_n = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      dout_q <= '0;
      mdi_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      dout_q <= dout_n;
      mdi_q  <= mdi_n;
    end
  end

  assign mdi   = mdi_q;
  assign state = st_q;
  assign cnt   = cnt_q;
  assign hist  = sh_q;

endmodule

// File: rtl/mdio_mgmt_target.sv
module mdio_mgmt_target
  import mdio_tgt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned ID_A_IDX = 2,
  parameter logic [DATA_W-1:0] ID_A_VAL = 16'h0022,
  parameter int unsigned ID_B_IDX = 3,
  parameter logic [DATA_W-1:0] ID_B_VAL = 16'h161A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdo,
  input  logic mdo_oe,
  output logic mdi
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 2);

  logic              mdc_rise, mdc_bit, rf_we;
  logic [ADDR_W-1:0] rf_raddr, rf_waddr;
  logic [DATA_W-1:0] rf_rdata, rf_wdata;
  frm_state_e        frm_state;
  logic [CNT_W-1:0]  data_cnt;
  logic [2*DATA_W-1:0] bit_hist;

  mdio_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .mdc    (mdc),
    .mdo    (mdo),
    .mdo_oe (mdo_oe),
    .rise   (mdc_rise),
    .bit_in (mdc_bit)
  );

  mdio_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (mdc_rise),
    .bit_in  (mdc_bit),
    .rd_data (rf_rdata),
    .rd_addr (rf_raddr),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .mdi     (mdi),
    .state   (frm_state),
    .cnt     (data_cnt),
    .hist    (bit_hist)
  );

  mdio_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ID_A_IDX(ID_A_IDX), .ID_A_VAL(ID_A_VAL),
    .ID_B_IDX(ID_B_IDX), .ID_B_VAL(ID_B_VAL)
  ) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

endmodule

// File: rtl/mdio_mgmt_target_chk.sv
module mdio_mgmt_target_chk
  import mdio_tgt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mdc_rise,
  input logic              mdc_bit,
  input logic              rf_we,
  input logic              mdi,
  input frm_state_e        frm_state,
  input logic [CNT_W-1:0]  data_cnt,
  input logic [2*DATA_W-1:0] bit_hist
);

  assert_mdi_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_state != ST_RD) |-> !mdi);

  assert_no_edge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mdc_rise |=> ($stable(frm_state) && $stable(mdi) && $stable(data_cnt)));

  assert_write_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mdc_rise && frm_state == ST_WR));

  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_state != ST_IDLE) |-> (data_cnt != '0 && data_cnt <= CNT_W'(DATA_W)));

  assert_ones_resync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_rise && mdc_bit && (&bit_hist[2*DATA_W-2:0]))
      |=> (frm_state == ST_IDLE && data_cnt == '0));

endmodule

bind mdio_mgmt_target mdio_mgmt_target_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mdc_rise  (mdc_rise),
  .mdc_bit   (mdc_bit),
  .rf_we     (rf_we),
  .mdi       (mdi),
  .frm_state (frm_state),
  .data_cnt  (data_cnt),
  .bit_hist  (bit_hist)
);

// File: tb/mdio_mgmt_target_tb.sv
module mdio_mgmt_target_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b0;
  logic mdo = 1'b0;
  logic mdo_oe = 1'b0;
  logic mdi;

  int checks = 0;
  int errors = 0;
  logic tail_mdi;

  always #4 clk = ~clk;

  mdio_mgmt_target u_dut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe), .mdi(mdi)
  );

  // vector: {register, phy used for write, phy used for read, data}
  localparam int NVEC = 5;
  localparam logic [30:0] VEC [NVEC] = '{
    {5'd4,  5'd0,  5'd31, 16'hA5C3},
    {5'd31, 5'd1,  5'd1,  16'h8001},
    {5'd0,  5'd17, 5'd3,  16'hFFFF},
    {5'd3,  5'd9,  5'd22, 16'h0F0E},
    {5'd7,  5'd30, 5'd7,  16'h5A5A}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic d, input logic oe, output logic seen);
    mdo = d; mdo_oe = oe; mdc = 1'b0;
    repeat (2) @(negedge clk);
    mdc = 1'b1;
    repeat (2) @(negedge clk);
    seen = mdi;
  endtask

  task automatic preamble();
    logic s;
    for (int i = 0; i < 32; i++) send_bit(1'b1, 1'b1, s);
  endtask

  task automatic do_write(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [1:0] ta, input logic [15:0] data,
                          input logic oe_data, input logic pre);
    logic s;
    logic [13:0] hdr;
    hdr = {st, op, phy, rg};
    if (pre) preamble();
    for (int i = 13; i >= 0; i--) send_bit(hdr[i], 1'b1, s);
    send_bit(ta[1], 1'b1, s);
    send_bit(ta[0], 1'b1, s);
    for (int i = 15; i >= 0; i--) send_bit(data[i], oe_data, s);
    tail_mdi = s;
  endtask

  task automatic do_read(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [1:0] ta, input logic ta_drv,
                         input logic pre, output logic [15:0] val);
    logic s;
    logic [13:0] hdr;
    hdr = {st, op, phy, rg};
    if (pre) preamble();
    for (int i = 13; i >= 0; i--) send_bit(hdr[i], 1'b1, s);
    send_bit(ta[1], ta_drv, s);
    send_bit(ta[0], ta_drv, s);
    val[15] = s;
    for (int k = 14; k >= 0; k--) begin
      send_bit(1'b0, 1'b0, s);
      val[k] = s;
    end
    send_bit(1'b0, 1'b0, s);
    tail_mdi = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [4:0] rg, pw, pr;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 mdi after reset", {15'd0, mdi}, 16'h0000);
    do_read(2'b01, 2'b10, 5'd0, 5'd2, 2'b00, 1'b0, 1'b1, v);
    check("R1 identifier entry 2", v, 16'h0022);
    check("R7 mdi low after read end", {15'd0, tail_mdi}, 16'h0000);
    do_read(2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 1'b0, 1'b1, v);
    check("R1 identifier entry 3", v, 16'h161A);
    do_read(2'b01, 2'b10, 5'd0, 5'd5, 2'b00, 1'b0, 1'b1, v);
    check("R1 plain entry zero", v, 16'h0000);

    // vector table: write then read back (R4 R7 R8 R9)
    for (int n = 0; n < NVEC; n++) begin
      {rg, pw, pr, d} = VEC[n];
      do_write(2'b01, 2'b01, pw, rg, 2'b10, d, 1'b1, 1'b1);
      check("R10 mdi low during write", {15'd0, tail_mdi}, 16'h0000);
      do_read(2'b01, 2'b10, pr, rg, 2'b00, 1'b0, 1'b1, v);
      check("R8 R9 R4 R7 table readback", v, d);
    end

    // R5 rejected writes leave entry 7 (0x5A5A) unchanged
    do_write(2'b01, 2'b01, 5'd0, 5'd7, 2'b11, 16'h1111, 1'b1, 1'b1);
    do_read(2'b01, 2'b10, 5'd0, 5'd7, 2'b00, 1'b0, 1'b1, v);
    check("R5 turnaround 11 write ignored", v, 16'h5A5A);
    do_write(2'b00, 2'b01, 5'd0, 5'd7, 2'b10, 16'h2222, 1'b1, 1'b1);
    do_read(2'b01, 2'b10, 5'd0, 5'd7, 2'b00, 1'b0, 1'b1, v);
    check("R5 start 00 write ignored", v, 16'h5A5A);

    // R6 read turnaround rules (entry 4 holds 0xA5C3)
    do_read(2'b01, 2'b10, 5'd2, 5'd4, 2'b10, 1'b1, 1'b1, v);
    check("R6 read with turnaround 10", v, 16'hA5C3);
    do_read(2'b01, 2'b10, 5'd2, 5'd4, 2'b01, 1'b1, 1'b1, v);
    check("R6 read with turnaround 01 rejected", v, 16'h0000);
    do_read(2'b01, 2'b11, 5'd2, 5'd4, 2'b00, 1'b0, 1'b1, v);
    check("R6 read with opcode 11 rejected", v, 16'h0000);

    // R3 after a rejected header, no decode until a run of ones
    do_write(2'b11, 2'b01, 5'd0, 5'd9, 2'b10, 16'h1234, 1'b1, 1'b1);
    do_write(2'b01, 2'b01, 5'd0, 5'd9, 2'b10, 16'hBEEF, 1'b1, 1'b0);
    do_read(2'b01, 2'b10, 5'd0, 5'd9, 2'b00, 1'b0, 1'b1, v);
    check("R3 misaligned write lost", v, 16'h0000);
    do_write(2'b01, 2'b01, 5'd0, 5'd9, 2'b10, 16'hBEEF, 1'b1, 1'b1);
    do_read(2'b01, 2'b10, 5'd0, 5'd9, 2'b00, 1'b0, 1'b1, v);
    check("R3 realigned write taken", v, 16'hBEEF);

    // R8 back-to-back frames without a run of ones
    do_write(2'b01, 2'b01, 5'd0, 5'd10, 2'b10, 16'hC001, 1'b1, 1'b1);
    do_write(2'b01, 2'b01, 5'd0, 5'd11, 2'b10, 16'h0DD0, 1'b1, 1'b0);
    do_read(2'b01, 2'b10, 5'd0, 5'd10, 2'b00, 1'b0, 1'b0, v);
    check("R8 first back-to-back write", v, 16'hC001);
    do_read(2'b01, 2'b10, 5'd0, 5'd11, 2'b00, 1'b0, 1'b0, v);
    check("R8 second back-to-back write", v, 16'h0DD0);

    // R2 data with enable low is taken as zero
    do_write(2'b01, 2'b01, 5'd0, 5'd12, 2'b10, 16'hFFFF, 1'b0, 1'b1);
    do_read(2'b01, 2'b10, 5'd0, 5'd12, 2'b00, 1'b0, 1'b1, v);
    check("R2 enable low gives zero bits", v, 16'h0000);

    // R2 mdo toggling while mdc holds still shifts nothing
    preamble();
    mdc = 1'b0;
    mdo_oe = 1'b1;
    for (int i = 0; i < 20; i++) begin
      mdo = i[0];
      @(negedge clk);
    end
    mdc = 1'b1;
    for (int i = 0; i < 20; i++) begin
      mdo = ~i[0];
      @(negedge clk);
    end
    do_write(2'b01, 2'b01, 5'd0, 5'd13, 2'b10, 16'h7E81, 1'b1, 1'b0);
    do_read(2'b01, 2'b10, 5'd0, 5'd13, 2'b00, 1'b0, 1'b1, v);
    check("R2 no shift without mdc edge", v, 16'h7E81);
    check("R10 mdi low in idle", {15'd0, mdi}, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule